// File: doc/BRIEF.md
# Addressable system control latch

This block turns CPU byte writes into a small set of single-bit system control flags, in the way an addressable latch works. The data bus is not used at all. For a write that falls in the flag window, address bits 3..1 pick one of eight flags and address bit 4 carries the state to write. The flags drive video darkening, the vector table source, two memory-card write unlocks, the card register-select line, the fixed-graphics and sound ROM source, backup RAM protection and the palette bank. The memory-card write enable is the AND of both unlocks.

A second window holds four coin strobes. A write of any data there sets or releases one of two coin counters or one of two coin lockouts. Each coin output is an active-high sink-enable bit. Address bit 7 gives its new state and address bits 2..1 pick the output.

Both windows sit at parameterised base addresses. A test-only port shows all eight flags and all four coin bits, so that every write can be checked at once.

Top module: `sysctl_latch`

## Requirements
- R1: A synchronous reset clears all eight flags and all four coin bits to 0. This gives normal video, built-in vectors, both card unlocks clear, register select off, embedded ROMs, backup RAM unprotected, palette bank 0 and all coin outputs released. The zeros show from the first clock edge at which reset is sampled high.
- R2: A write takes effect only when all of these hold: wr_en is high, wr_byte is high (byte access), addr[0] is 1, and the address lies in one of the two windows. The flag window is addr[23:5] equal to the flag base. The coin window is addr[23:8] equal to the coin base with addr[6:3] = 4'b1100. Any other access changes nothing, and the value on wr_data never matters.
- R3: In the flag window, addr[3:1] selects the flag and addr[4] gives the state to write. Exactly that one flag can change, and the others keep their values.
- R4: Flag offset 0x11 turns video darkening on and 0x01 turns it off. Offset 0x13 selects the cartridge vector table (vec_cart=1) and 0x03 selects the built-in one.
- R5: Offset 0x05 sets card unlock A and 0x15 clears it. Unlock B has the opposite polarity: 0x17 sets it and 0x07 clears it. card_we_en is 1 exactly while both unlocks are set.
- R6: Offset 0x09 turns card register select on and 0x19 turns it off. Offset 0x1B selects the cartridge fixed-graphics and sound ROMs (fix_cart=1) and 0x0B selects the embedded ones.
- R7: Offset 0x0D write-protects backup RAM and 0x1D unprotects it. Offset 0x0F selects palette bank 1 (pal_bank1=1) and 0x1F selects bank 0.
- R8: In the coin window, addr[7]=1 makes the selected output sink and addr[7]=0 releases it. addr[2:1] selects the output, and only that one output changes. The coin_sink bits are: bit 0 counter 1 (offsets 0x61/0xE1), bit 1 counter 2 (0x63/0xE3), bit 2 lockout 1 (0x65/0xE5), bit 3 lockout 2 (0x67/0xE7).
- R9: test_flags bit order is: 0 darken, 1 cartridge vectors, 2 unlock A, 3 unlock B, 4 register select, 5 cartridge ROMs, 6 backup RAM protect, 7 palette bank 1. Each named output equals its test_flags bit. test_coin equals coin_sink.
- R10: A qualified write updates state on the clock edge that samples it, and the result is visible right after that edge. Without a qualified write, the state holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wr_byte | input | 1 | 1 for a byte access, 0 for a word access |
| addr | input | ADDR_W (24) | Write address; selects flag or coin output and the new state |
| wr_data | input | DATA_W (8) | Write data, ignored |
| video_dark | output | 1 | Darken video output |
| vec_cart | output | 1 | 1: cartridge vector table, 0: built-in |
| card_we_en | output | 1 | Memory-card write enable (both unlocks set) |
| card_regsel | output | 1 | Memory-card register-select line |
| fix_cart | output | 1 | 1: cartridge fixed-graphics and sound ROMs, 0: embedded |
| bram_protect | output | 1 | Backup RAM write protection |
| pal_bank1 | output | 1 | 1: palette bank 1, 0: bank 0 |
| coin_sink | output | 4 | Coin counter and lockout sink enables |
| test_flags | output | 8 | Test view of all eight flags |
| test_coin | output | 4 | Test view of the four coin bits |

## Verification
Every stored bit comes out directly on both a named output and the test port. A wrong decode, a wrong polarity or a write landing on the wrong bit therefore shows as a mismatch in the cycle right after the faulty write, and it stays there until the same bit is written again. A fault in the two-unlock combination shows only on card_we_en, and only while exactly one unlock is set. The stimulus walks through those half-unlocked states on purpose. An access that should be ignored but is not shows as an unexpected change one cycle after it.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

   localparam int unsigned FLAG_SEL_W = 3;
   localparam int unsigned NUM_FLAGS  = 1 << FLAG_SEL_W;
   localparam int unsigned COIN_SEL_W = 2;
   localparam int unsigned NUM_COIN   = 1 << COIN_SEL_W;

   // flag positions inside the flag bank (bit index = addr[3:1])
   typedef enum logic [FLAG_SEL_W-1:0] {
      FLG_DARK      = 3'd0,
      FLG_VEC_CART  = 3'd1,
      FLG_UNLOCK_A  = 3'd2,
      FLG_UNLOCK_B  = 3'd3,
      FLG_REGSEL    = 3'd4,
      FLG_FIX_CART  = 3'd5,
      FLG_BRAM_PROT = 3'd6,
      FLG_PAL1      = 3'd7
   } flag_idx_e;

   // flags whose meaning is active when addr[4] is 0
   localparam logic [NUM_FLAGS-1:0] FLAG_INVERT = 8'b1101_0100;
   localparam logic [NUM_FLAGS-1:0] FLAG_RESET  = '0;

   typedef enum logic [COIN_SEL_W-1:0] {
      COIN_CTR1  = 2'd0,
      COIN_CTR2  = 2'd1,
      COIN_LOCK1 = 2'd2,
      COIN_LOCK2 = 2'd3
   } coin_idx_e;

   localparam logic [NUM_COIN-1:0] COIN_INVERT = '0;
   localparam logic [NUM_COIN-1:0] COIN_RESET  = '0;

endpackage

// File: rtl/sysctl_win_dec.sv
module sysctl_win_dec #(
   parameter int unsigned          ADDR_W    = 24,
   parameter logic [ADDR_W-1:0]    BASE      = '0,
   parameter int unsigned          MATCH_LSB = 5,
   parameter int unsigned          VAL_BIT   = 4,
   parameter int unsigned          SEL_LSB   = 1,
   parameter int unsigned          SEL_W     = 3,
   parameter int unsigned          FIX_LSB   = 3,
   parameter int unsigned          FIX_W     = 0,
   parameter logic [7:0]           FIX_VAL   = '0
) (
   input  logic              acc_ok,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [SEL_W-1:0]  sel,
   output logic              val
);

   localparam int unsigned MATCH_W = ADDR_W - MATCH_LSB;

   if (MATCH_LSB <= VAL_BIT || MATCH_LSB <= SEL_LSB + SEL_W - 1) begin : g_bad_layout
      $error("sysctl_win_dec: window match bits overlap the decoded field");
   end
   if (SEL_LSB == 0) begin : g_bad_sel
      $error("sysctl_win_dec: bit 0 is reserved for the odd-byte check");
   end

   logic base_match;
   logic fix_match;

   assign base_match = (addr[ADDR_W-1:MATCH_LSB] == BASE[ADDR_W-1:MATCH_LSB]);

   if (FIX_W == 0) begin : g_nofix
      assign fix_match = 1'b1;
   end else begin : g_fix
      assign fix_match = (addr[FIX_LSB +: FIX_W] == FIX_VAL[FIX_W-1:0]);
   end

   // only odd byte addresses are mapped
   assign hit = acc_ok & addr[0] & base_match & fix_match;
   assign sel = addr[SEL_LSB +: SEL_W];
   assign val = addr[VAL_BIT];

   logic unused_match_w;
   assign unused_match_w = (MATCH_W == 0);

endmodule

// File: rtl/sysctl_addr_latch.sv
module sysctl_addr_latch #(
   parameter int unsigned     SEL_W   = 3,
   parameter int unsigned     N       = 1 << SEL_W,
   parameter logic [N-1:0]    RST_VAL = '0,
   parameter logic [N-1:0]    INVERT  = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_hit,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic             wr_val,
   output logic [N-1:0]     q
);

   if (N != (1 << SEL_W)) begin : g_bad_n
      $error("sysctl_addr_latch: N must equal 2**SEL_W");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic bit_we;
      logic bit_d;
      assign bit_we = wr_hit && (wr_sel == SEL_W'(i));
      assign bit_d  = wr_val ^ INVERT[i];

      always_ff @(posedge clk) begin
         if (rst) begin
            q[i] <= RST_VAL[i];
         end else if (bit_we) begin
            q[i] <= bit_d;
         end
      end
   end

endmodule

// File: rtl/sysctl_latch.sv
module sysctl_latch
   import sysctl_pkg::*;
#(
   parameter int unsigned       ADDR_W    = 24,
   parameter int unsigned       DATA_W    = 8,
   parameter logic [ADDR_W-1:0] FLAG_BASE = 'h3A0000,
   parameter logic [ADDR_W-1:0] COIN_BASE = 'h380000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic              wr_byte,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              video_dark,
   output logic              vec_cart,
   output logic              card_we_en,
   output logic              card_regsel,
   output logic              fix_cart,
   output logic              bram_protect,
   output logic              pal_bank1,
   output logic [3:0]        coin_sink,
   output logic [7:0]        test_flags,
   output logic [3:0]        test_coin
);

   localparam int unsigned FLAG_MATCH_LSB = FLAG_SEL_W + 2;
   localparam int unsigned COIN_MATCH_LSB = 8;

   if (ADDR_W < COIN_MATCH_LSB + 1) begin : g_bad_addr_w
      $error("sysctl_latch: ADDR_W too small for the coin window");
   end
   if (FLAG_BASE[FLAG_MATCH_LSB-1:0] != '0) begin : g_bad_flag_base
      $error("sysctl_latch: FLAG_BASE must be aligned to the flag window");
   end
   if (COIN_BASE[COIN_MATCH_LSB-1:0] != '0) begin : g_bad_coin_base
      $error("sysctl_latch: COIN_BASE must be aligned to the coin window");
   end
   if (FLAG_BASE[ADDR_W-1:COIN_MATCH_LSB] == COIN_BASE[ADDR_W-1:COIN_MATCH_LSB]) begin : g_overlap
      $error("sysctl_latch: flag and coin windows overlap");
   end

   logic                  acc_ok;
   logic                  flag_hit, flag_val;
   logic [FLAG_SEL_W-1:0] flag_sel;
   logic                  coin_hit, coin_val;
   logic [COIN_SEL_W-1:0] coin_sel;
   logic [NUM_FLAGS-1:0]  flags;
   logic [NUM_COIN-1:0]   coins;

   assign acc_ok = wr_en & wr_byte;

   sysctl_win_dec #(
      .ADDR_W    (ADDR_W),
      .BASE      (FLAG_BASE),
      .MATCH_LSB (FLAG_MATCH_LSB),
      .VAL_BIT   (FLAG_SEL_W + 1),
      .SEL_LSB   (1),
      .SEL_W     (FLAG_SEL_W),
      .FIX_LSB   (0),
      .FIX_W     (0),
      .FIX_VAL   (8'h00)
   ) u_flag_dec (
      .acc_ok (acc_ok),
      .addr   (addr),
      .hit    (flag_hit),
      .sel    (flag_sel),
      .val    (flag_val)
   );

   sysctl_win_dec #(
      .ADDR_W    (ADDR_W),
      .BASE      (COIN_BASE),
      .MATCH_LSB (COIN_MATCH_LSB),
      .VAL_BIT   (7),
      .SEL_LSB   (1),
      .SEL_W     (COIN_SEL_W),
      .FIX_LSB   (3),
      .FIX_W     (4),
      .FIX_VAL   (8'h0C)
   ) u_coin_dec (
      .acc_ok (acc_ok),
      .addr   (addr),
      .hit    (coin_hit),
      .sel    (coin_sel),
      .val    (coin_val)
   );

   sysctl_addr_latch #(
      .SEL_W   (FLAG_SEL_W),
      .N       (NUM_FLAGS),
      .RST_VAL (FLAG_RESET),
      .INVERT  (FLAG_INVERT)
   ) u_flag_bank (
      .clk    (clk),
      .rst    (rst),
      .wr_hit (flag_hit),
      .wr_sel (flag_sel),
      .wr_val (flag_val),
      .q      (flags)
   );

   sysctl_addr_latch #(
      .SEL_W   (COIN_SEL_W),
      .N       (NUM_COIN),
      .RST_VAL (COIN_RESET),
      .INVERT  (COIN_INVERT)
   ) u_coin_bank (
      .clk    (clk),
      .rst    (rst),
      .wr_hit (coin_hit),
      .wr_sel (coin_sel),
      .wr_val (coin_val),
      .q      (coins)
   );

   assign video_dark   = flags[FLG_DARK];
   assign vec_cart     = flags[FLG_VEC_CART];
   assign card_regsel  = flags[FLG_REGSEL];
   assign fix_cart     = flags[FLG_FIX_CART];
   assign bram_protect = flags[FLG_BRAM_PROT];
   assign pal_bank1    = flags[FLG_PAL1];
   // card writes need both unlock flags
   assign card_we_en   = flags[FLG_UNLOCK_A] & flags[FLG_UNLOCK_B];

   assign coin_sink  = coins;
   assign test_flags = flags;
   assign test_coin  = coins;

   logic data_unused;
   assign data_unused = ^wr_data;

endmodule

// File: rtl/sysctl_latch_chk.sv
module sysctl_latch_chk (
   input logic       clk,
   input logic       rst,
   input logic       wr_en,
   input logic       wr_byte,
   input logic       a0,
   input logic [1:0] a32,
   input logic       a7,
   input logic       card_we_en,
   input logic [7:0] test_flags,
   input logic [3:0] test_coin
);

   // R1: reset sampled high leaves every bit cleared after that edge
   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (test_flags == 8'h00 && test_coin == 4'h0))
      else $error("a_r1_reset_clears");

   // R2: an access that is not an odd byte write changes no state
   a_r2_unqualified_ignored: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && wr_byte && a0) |=> ($stable(test_flags) && $stable(test_coin)))
      else $error("a_r2_unqualified_ignored");

   // R3: at most one flag changes per edge
   a_r3_single_flag_change: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> ($countones(test_flags ^ $past(test_flags)) <= 1))
      else $error("a_r3_single_flag_change");

   // R5: card enable only rises right after a write to an unlock flag
   a_r5_card_en_after_unlock: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $rose(card_we_en)) |-> $past(wr_en && a0 && a32 == 2'b01))
      else $error("a_r5_card_en_after_unlock");

   // R8: at most one coin output changes per edge
   a_r8_single_coin_change: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> ($countones(test_coin ^ $past(test_coin)) <= 1))
      else $error("a_r8_single_coin_change");

   // R8: a coin output only starts sinking after a write with addr[7] high
   a_r8_sink_needs_bit7: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && ((test_coin & ~$past(test_coin)) != 4'h0)) |-> $past(a7))
      else $error("a_r8_sink_needs_bit7");

endmodule

bind sysctl_latch sysctl_latch_chk u_chk (
   .clk        (clk),
   .rst        (rst),
   .wr_en      (wr_en),
   .wr_byte    (wr_byte),
   .a0         (addr[0]),
   .a32        (addr[3:2]),
   .a7         (addr[7]),
   .card_we_en (card_we_en),
   .test_flags (test_flags),
   .test_coin  (test_coin)
);

// File: tb/sysctl_latch_tb.sv
module sysctl_latch_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 28;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic        wr_byte = 1'b0;
   logic [23:0] addr = '0;
   logic [7:0]  wr_data = '0;
   logic        video_dark, vec_cart, card_we_en, card_regsel;
   logic        fix_cart, bram_protect, pal_bank1;
   logic [3:0]  coin_sink, test_coin;
   logic [7:0]  test_flags;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sysctl_latch u_dut (
      .clk          (clk),
      .rst          (rst),
      .wr_en        (wr_en),
      .wr_byte      (wr_byte),
      .addr         (addr),
      .wr_data      (wr_data),
      .video_dark   (video_dark),
      .vec_cart     (vec_cart),
      .card_we_en   (card_we_en),
      .card_regsel  (card_regsel),
      .fix_cart     (fix_cart),
      .bram_protect (bram_protect),
      .pal_bank1    (pal_bank1),
      .coin_sink    (coin_sink),
      .test_flags   (test_flags),
      .test_coin    (test_coin)
   );

   // {addr, byte access, data, expected flags, expected coin bits}
   localparam logic [44:0] VEC [NV] = '{
      {24'h3A0011, 1'b1, 8'h00, 8'h01, 4'h0},
      {24'h3A0013, 1'b1, 8'h5A, 8'h03, 4'h0},
      {24'h3A0005, 1'b1, 8'hFF, 8'h07, 4'h0},
      {24'h3A0017, 1'b1, 8'h00, 8'h0F, 4'h0},
      {24'h3A0015, 1'b1, 8'h00, 8'h0B, 4'h0},
      {24'h3A0005, 1'b1, 8'h00, 8'h0F, 4'h0},
      {24'h3A0007, 1'b1, 8'h00, 8'h07, 4'h0},
      {24'h3A0009, 1'b1, 8'h00, 8'h17, 4'h0},
      {24'h3A001B, 1'b1, 8'h00, 8'h37, 4'h0},
      {24'h3A000D, 1'b1, 8'h00, 8'h77, 4'h0},
      {24'h3A000F, 1'b1, 8'h00, 8'hF7, 4'h0},
      {24'h3A001F, 1'b1, 8'hFF, 8'h77, 4'h0},
      {24'h3A0001, 1'b1, 8'h00, 8'h76, 4'h0},
      {24'h3A0003, 1'b1, 8'h00, 8'h74, 4'h0},
      {24'h3800E1, 1'b1, 8'h00, 8'h74, 4'h1},
      {24'h3800E7, 1'b1, 8'h00, 8'h74, 4'h9},
      {24'h3800E3, 1'b1, 8'h00, 8'h74, 4'hB},
      {24'h3800E5, 1'b1, 8'hA5, 8'h74, 4'hF},
      {24'h380063, 1'b1, 8'h00, 8'h74, 4'hD},
      {24'h380061, 1'b1, 8'hFF, 8'h74, 4'hC},
      {24'h380067, 1'b1, 8'h00, 8'h74, 4'h4},
      {24'h3A001D, 1'b0, 8'h00, 8'h74, 4'h4},
      {24'h3A001D, 1'b1, 8'h00, 8'h34, 4'h4},
      {24'h3A000C, 1'b1, 8'h00, 8'h34, 4'h4},
      {24'h3A0031, 1'b1, 8'h00, 8'h34, 4'h4},
      {24'h3800A1, 1'b1, 8'h00, 8'h34, 4'h4},
      {24'h3800E4, 1'b1, 8'h00, 8'h34, 4'h4},
      {24'h3A0019, 1'b1, 8'h00, 8'h24, 4'h4}
   };

   function automatic string row_tag(int i);
      case (i)
         0, 1, 12, 13:           return "R4";
         2, 3, 4, 5, 6:          return "R5";
         7, 8, 27:               return "R6";
         9, 10, 11, 22:          return "R7";
         14, 15, 16, 17, 18, 19, 20: return "R8";
         default:                return "R2";
      endcase
   endfunction

   task automatic cmp(string tag, string what, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic check_state(string tag, logic [7:0] ef, logic [3:0] ec);
      cmp(tag, "test_flags", test_flags, ef);
      cmp(tag, "test_coin", {4'h0, test_coin}, {4'h0, ec});
      // R9: named outputs follow the documented bit order
      cmp("R9", "named flag outputs",
          {pal_bank1, bram_protect, fix_cart, card_regsel, 2'b00, vec_cart, video_dark},
          {ef[7], ef[6], ef[5], ef[4], 2'b00, ef[1], ef[0]});
      cmp("R9", "coin_sink", {4'h0, coin_sink}, {4'h0, ec});
      // R5: card enable needs unlock A (bit 2) and unlock B (bit 3)
      cmp("R5", "card_we_en", {7'h0, card_we_en}, {7'h0, ef[2] & ef[3]});
   endtask

   task automatic do_write(logic [23:0] a, logic b, logic [7:0] d, logic en);
      @(negedge clk);
      wr_en   = en;
      wr_byte = b;
      addr    = a;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
      wr_byte = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: state after the initial reset
      check_state("R1", 8'h00, 4'h0);
      rst = 1'b0;
      @(negedge clk);
      check_state("R1", 8'h00, 4'h0);

      for (int i = 0; i < NV; i++) begin
         logic [23:0] a;
         logic        b;
         logic [7:0]  d;
         logic [7:0]  ef;
         logic [3:0]  ec;
         {a, b, d, ef, ec} = VEC[i];
         do_write(a, b, d, 1'b1);
         check_state(row_tag(i), ef, ec);
      end

      // R10 and R2: wr_en low with a valid address holds state
      @(negedge clk);
      wr_en = 1'b0; wr_byte = 1'b1; addr = 24'h3A0011; wr_data = 8'h00;
      repeat (3) @(negedge clk);
      check_state("R10", 8'h24, 4'h4);
      wr_byte = 1'b0;

      // R3 and R10: one write changes one flag, visible right after its edge
      do_write(24'h3A0011, 1'b1, 8'h33, 1'b1);
      check_state("R3", 8'h25, 4'h4);
      do_write(24'h3A0015, 1'b1, 8'h00, 1'b1);
      check_state("R3", 8'h21, 4'h4);

      // R1: reset in the middle of a run
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check_state("R1", 8'h00, 4'h0);
      rst = 1'b0;
      @(negedge clk);
      check_state("R1", 8'h00, 4'h0);

      // R5: unlock B alone does not enable card writes
      do_write(24'h3A0017, 1'b1, 8'h00, 1'b1);
      check_state("R5", 8'h08, 4'h0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule